// File: doc/BRIEF.md
# AUX Request Framer and Reply Decoder

This block sits in front of a display auxiliary-channel transfer engine. It takes one request record (a 4-bit command, a 20-bit target address, a payload size and the write payload) and builds the byte frame the engine must transmit. It also computes how many bytes the engine may accept back and flags requests that cannot be framed. When the engine returns a reply, the block turns the reply bytes into a reply code and a byte count, and for reads it also outputs the returned payload.

A request is offered with a one-cycle `req_valid` pulse. The frame, its length, the reply capacity and the error and key flags are registered one cycle later and hold until the next request. A reply is offered with a one-cycle `rx_valid` pulse. It is decoded against the most recent request, and the result is registered one cycle later. One write target is special: a native write to the key-select address raises `key_insert`. This flag tells the engine to append its own key bytes after the header. The transfer timing and the retry policy belong to the engine.

Top module: `aux_frame_fmt`

## Requirements
- R1: Frame byte i is `tx_data[8*i+7:8*i]`. Byte 0 is {command, address[19:16]}, byte 1 is address[15:8], byte 2 is address[7:0] and byte 3 is size minus 1 (8-bit). For a write, byte 4+k is payload byte k, taken from `req_wdata[8*k+7:8*k]`. Every byte at an offset of `tx_len` or above reads zero.
- R2: Write commands are 4'h8 (native write), 4'h0 (I2C write) and 4'h2 (I2C write-status-update). For these, `tx_len` is 4+size when size is nonzero and 3 when size is zero, and `rx_cap` is 2.
- R3: Read commands are 4'h9 (native read) and 4'h1 (I2C read). For these, `tx_len` is 4 when size is nonzero and 3 when size is zero, and `rx_cap` is size+1.
- R4: Command bit 2 (the middle-of-transaction bit) is ignored when a command is classified. Byte 0 still carries the full command.
- R5: A read or write whose `tx_len` or `rx_cap` would exceed 20 sets `err_big`. It also forces `tx_len`, `rx_cap`, `key_insert` and every frame byte to zero.
- R6: Any other command sets `err_inval`. It forces `tx_len`, `rx_cap`, `key_insert` and every frame byte to zero.
- R7: `key_insert` is 1 only for a command that reads 4'h8 once bit 2 is ignored, sent to address 20'h68007, that does not raise `err_big`.
- R8: `res_code` is bits [7:4] of reply byte 0 (`rx_data[7:4]`).
- R9: For a write, the effective reply length is min(`rx_len`, 2). When it is 2, `res_count` is min(reply byte 1, size). Otherwise `res_count` is the request size. `rd_data` is all zero.
- R10: For a read, the effective length L is min(`rx_len`, size+1). `res_count` is L-1, or 0 when L is 0. Byte i of `rd_data` is reply byte i+1 for i < L-1, and zero beyond that.
- R11: `tx_valid` pulses in the cycle after `req_valid`, and `res_valid` pulses in the cycle after `rx_valid`. The registered outputs hold between pulses. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 4 | Request command |
| req_addr | input | 20 | Target address |
| req_size | input | 5 | Payload size in bytes |
| req_wdata | input | 128 | Write payload, byte k at bits 8k+7:8k |
| tx_valid | output | 1 | New frame available |
| tx_data | output | 160 | Frame bytes, byte i at bits 8i+7:8i |
| tx_len | output | 5 | Bytes to transmit |
| rx_cap | output | 5 | Reply byte capacity |
| key_insert | output | 1 | Engine must append its key bytes |
| err_big | output | 1 | Request exceeds frame limit |
| err_inval | output | 1 | Command is neither read nor write |
| rx_valid | input | 1 | Reply strobe |
| rx_len | input | 5 | Reply bytes received |
| rx_data | input | 160 | Reply bytes, byte i at bits 8i+7:8i |
| res_valid | output | 1 | Decoded result available |
| res_code | output | 4 | Reply code |
| res_count | output | 5 | Payload or short-write count |
| rd_data | output | 152 | Read payload, byte i at bits 8i+7:8i |

## Verification
The bound checker checks, on every cycle, the relations that hold whatever the data is. These are the pulse timing of both strobes, header address and command bytes that match the request captured one cycle earlier, zero lengths and no key flag on either error, bounded lengths, the key flag appearing only with a write-sized reply capacity, and a reply code that matches the top nibble of the reply. The effect of each size depends on the command, so the exact values can only be shown by the directed scenarios. These values are the address-only zero-size frames, the 20-byte boundaries on both sides, the clamping of the short-write count, the cut-down reply length for reads, and the key flag with the middle-of-transaction bit set.

// File: rtl/auxf_pkg.sv
// Package: shared constants and command classification for the AUX framer.
// Assumes a 4-bit command whose bit 2 marks middle-of-transaction.
package auxf_pkg;

    localparam int ADDR_W = 20;
    localparam logic [3:0] CONT_BIT  = 4'b0100;
    localparam logic [3:0] NAT_WR    = 4'h8;
    localparam logic [3:0] NAT_RD    = 4'h9;
    localparam logic [3:0] I2C_WR    = 4'h0;
    localparam logic [3:0] I2C_RD    = 4'h1;
    localparam logic [3:0] I2C_WRST  = 4'h2;

    typedef enum logic [1:0] {
        KIND_WRITE = 2'd0,
        KIND_READ  = 2'd1,
        KIND_BAD   = 2'd2
    } req_kind_e;

    // Sort a command into write, read or unsupported, ignoring the continue bit.
    function automatic req_kind_e classify(input logic [3:0] cmd);
        logic [3:0] base;
        base = cmd & ~CONT_BIT;
        case (base)
            NAT_WR, I2C_WR, I2C_WRST: classify = KIND_WRITE;
            NAT_RD, I2C_RD:           classify = KIND_READ;
            default:                  classify = KIND_BAD;
        endcase
    endfunction

endpackage

// File: rtl/auxf_hdr.sv
// Header builder: turns one request into a transmit frame, a transmit length,
// a reply capacity and the error / key flags. Purely combinational.
// Assumes a 4-byte header and 8-bit frame bytes; bytes past tx_len are zeroed.
module auxf_hdr
    import auxf_pkg::*;
#(
    parameter int MAX_FRAME = 20,
    parameter int HDR_LEN   = 4,
    parameter int SIZE_W    = 5,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 20'h68007,
    localparam int LEN_W    = $clog2(MAX_FRAME + 1),
    localparam int PAY_MAX  = MAX_FRAME - HDR_LEN
) (
    input  logic [3:0]             cmd,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [SIZE_W-1:0]      size,
    input  logic [PAY_MAX*8-1:0]   wdata,
    output logic [MAX_FRAME*8-1:0] frame,
    output logic [LEN_W-1:0]       tx_len,
    output logic [LEN_W-1:0]       rx_cap,
    output logic                   is_write,
    output logic                   err_big,
    output logic                   err_inval,
    output logic                   key_insert
);
    localparam int CW = SIZE_W + 3;

    req_kind_e       kind;
    logic [CW-1:0]   len_c;
    logic [CW-1:0]   cap_c;
    logic            big_c;
    logic [7:0]      size_m1;

    // Compute raw lengths by command kind, then apply the frame limit.
    always_comb begin
        kind = classify(cmd);
        len_c = '0;
        cap_c = '0;
        case (kind)
            KIND_WRITE: begin
                len_c = (size == '0) ? CW'(HDR_LEN - 1) : CW'(HDR_LEN) + CW'(size);
                cap_c = CW'(2);
            end
            KIND_READ: begin
                len_c = (size == '0) ? CW'(HDR_LEN - 1) : CW'(HDR_LEN);
                cap_c = CW'(size) + CW'(1);
            end
            default: begin
                len_c = '0;
                cap_c = '0;
            end
        endcase
        big_c      = (kind != KIND_BAD) &&
                     ((len_c > CW'(MAX_FRAME)) || (cap_c > CW'(MAX_FRAME)));
        err_big    = big_c;
        err_inval  = (kind == KIND_BAD);
        is_write   = (kind == KIND_WRITE);
        tx_len     = (big_c || kind == KIND_BAD) ? '0 : len_c[LEN_W-1:0];
        rx_cap     = (big_c || kind == KIND_BAD) ? '0 : cap_c[LEN_W-1:0];
        key_insert = ((cmd & ~CONT_BIT) == NAT_WR) && (addr == KEY_ADDR) && !big_c;
        size_m1    = 8'(size) - 8'd1;
    end

    // One lane per frame byte: pick header field or payload, zero past tx_len.
    for (genvar i = 0; i < MAX_FRAME; i++) begin : g_byte
        logic [7:0] raw;
        if (i == 0) begin : g_b0
            assign raw = {cmd, addr[19:16]};
        end else if (i == 1) begin : g_b1
            assign raw = addr[15:8];
        end else if (i == 2) begin : g_b2
            assign raw = addr[7:0];
        end else if (i == 3) begin : g_b3
            assign raw = size_m1;
        end else begin : g_pay
            assign raw = (CW'(i - HDR_LEN) < CW'(size)) ? wdata[8*(i-HDR_LEN) +: 8] : 8'h00;
        end
        assign frame[8*i +: 8] = (CW'(i) < CW'(tx_len)) ? raw : 8'h00;
    end

endmodule

// File: rtl/auxf_reply.sv
// Reply decoder: extracts the reply code and the result count, and for reads
// the payload, from a reply byte stream. Purely combinational.
// Assumes the caller supplies the kind and size of the request being answered.
module auxf_reply #(
    parameter int MAX_FRAME = 20,
    parameter int SIZE_W    = 5,
    localparam int LEN_W    = $clog2(MAX_FRAME + 1)
) (
    input  logic                       is_write,
    input  logic [SIZE_W-1:0]          size,
    input  logic [LEN_W-1:0]           rx_len,
    input  logic [MAX_FRAME*8-1:0]     rx_data,
    output logic [3:0]                 code,
    output logic [LEN_W-1:0]           count,
    output logic [(MAX_FRAME-1)*8-1:0] rd_data
);
    localparam int CW = SIZE_W + 3;

    logic [CW-1:0] cap;
    logic [CW-1:0] eff;
    logic [CW-1:0] cnt;
    logic [7:0]    wr_done;
    logic          unused_lo;

    assign unused_lo = ^rx_data[3:0];

    // Clip the reply length to capacity and derive the count.
    always_comb begin
        cap     = is_write ? CW'(2) : CW'(size) + CW'(1);
        eff     = (CW'(rx_len) < cap) ? CW'(rx_len) : cap;
        wr_done = rx_data[15:8];
        if (is_write) begin
            if (eff >= CW'(2))
                cnt = (CW'(wr_done) > CW'(size)) ? CW'(size) : CW'(wr_done);
            else
                cnt = CW'(size);
        end else begin
            cnt = (eff == '0) ? '0 : eff - CW'(1);
        end
        code  = rx_data[7:4];
        count = cnt[LEN_W-1:0];
    end

    // Read payload lanes: reply byte i+1 while inside the clipped length.
    for (genvar i = 0; i < MAX_FRAME - 1; i++) begin : g_rd
        assign rd_data[8*i +: 8] = (!is_write && (CW'(i + 1) < eff)) ?
                                   rx_data[8*(i+1) +: 8] : 8'h00;
    end

endmodule

// File: rtl/aux_frame_fmt.sv
// Top: registers the framed request and the decoded reply.
// Assumes one outstanding request; a reply is decoded against the last request.
module aux_frame_fmt
    import auxf_pkg::*;
#(
    parameter int MAX_FRAME = 20,
    parameter int HDR_LEN   = 4,
    parameter int SIZE_W    = 5,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 20'h68007,
    localparam int LEN_W    = $clog2(MAX_FRAME + 1),
    localparam int PAY_MAX  = MAX_FRAME - HDR_LEN
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [3:0]                 req_cmd,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [SIZE_W-1:0]          req_size,
    input  logic [PAY_MAX*8-1:0]       req_wdata,
    output logic                       tx_valid,
    output logic [MAX_FRAME*8-1:0]     tx_data,
    output logic [LEN_W-1:0]           tx_len,
    output logic [LEN_W-1:0]           rx_cap,
    output logic                       key_insert,
    output logic                       err_big,
    output logic                       err_inval,
    input  logic                       rx_valid,
    input  logic [LEN_W-1:0]           rx_len,
    input  logic [MAX_FRAME*8-1:0]     rx_data,
    output logic                       res_valid,
    output logic [3:0]                 res_code,
    output logic [LEN_W-1:0]           res_count,
    output logic [(MAX_FRAME-1)*8-1:0] rd_data
);
    logic [MAX_FRAME*8-1:0]     frame_c;
    logic [LEN_W-1:0]           len_c, cap_c;
    logic                       wr_c, big_c, inval_c, key_c;
    logic                       st_write;
    logic [SIZE_W-1:0]          st_size;
    logic [3:0]                 code_c;
    logic [LEN_W-1:0]           cnt_c;
    logic [(MAX_FRAME-1)*8-1:0] rd_c;

    auxf_hdr #(
        .MAX_FRAME (MAX_FRAME),
        .HDR_LEN   (HDR_LEN),
        .SIZE_W    (SIZE_W),
        .KEY_ADDR  (KEY_ADDR)
    ) u_hdr (
        .cmd        (req_cmd),
        .addr       (req_addr),
        .size       (req_size),
        .wdata      (req_wdata),
        .frame      (frame_c),
        .tx_len     (len_c),
        .rx_cap     (cap_c),
        .is_write   (wr_c),
        .err_big    (big_c),
        .err_inval  (inval_c),
        .key_insert (key_c)
    );

    auxf_reply #(
        .MAX_FRAME (MAX_FRAME),
        .SIZE_W    (SIZE_W)
    ) u_reply (
        .is_write (st_write),
        .size     (st_size),
        .rx_len   (rx_len),
        .rx_data  (rx_data),
        .code     (code_c),
        .count    (cnt_c),
        .rd_data  (rd_c)
    );

    // Capture the framed request and remember its kind and size for the reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid   <= 1'b0;
            tx_data    <= '0;
            tx_len     <= '0;
            rx_cap     <= '0;
            key_insert <= 1'b0;
            err_big    <= 1'b0;
            err_inval  <= 1'b0;
            st_write   <= 1'b0;
            st_size    <= '0;
        end else begin
            tx_valid <= req_valid;
            if (req_valid) begin
                tx_data    <= frame_c;
                tx_len     <= len_c;
                rx_cap     <= cap_c;
                key_insert <= key_c;
                err_big    <= big_c;
                err_inval  <= inval_c;
                st_write   <= wr_c;
                st_size    <= req_size;
            end
        end
    end

    // Capture the decoded reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= '0;
            res_count <= '0;
            rd_data   <= '0;
        end else begin
            res_valid <= rx_valid;
            if (rx_valid) begin
                res_code  <= code_c;
                res_count <= cnt_c;
                rd_data   <= rd_c;
            end
        end
    end

endmodule

// File: rtl/auxf_chk.sv
// Checker: cycle-level properties of the AUX framer, bound to the top module.
// Assumes the default frame limit of the top it is bound to.
module auxf_chk #(
    parameter int MAX_FRAME = 20,
    localparam int LEN_W    = $clog2(MAX_FRAME + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [3:0]       req_cmd,
    input logic [19:0]      req_addr,
    input logic             tx_valid,
    input logic [31:0]      tx_head,
    input logic [LEN_W-1:0] tx_len,
    input logic [LEN_W-1:0] rx_cap,
    input logic             key_insert,
    input logic             err_big,
    input logic             err_inval,
    input logic             rx_valid,
    input logic [3:0]       rx_hi,
    input logic             res_valid,
    input logic [3:0]       res_code
);
    AST_TX_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> tx_valid); // R11
    AST_TX_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(req_valid)); // R11
    AST_RES_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> res_valid); // R11
    AST_HDR_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_len != '0) |-> (tx_head[7:0] == {$past(req_cmd), $past(req_addr[19:16])} &&
            tx_head[15:8] == $past(req_addr[15:8]) && tx_head[23:16] == $past(req_addr[7:0]))); // R1
    AST_ADDR_ONLY_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_len == LEN_W'(3)) |-> (tx_head[31:24] == 8'h00)); // R2
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_len <= LEN_W'(MAX_FRAME)) && (rx_cap <= LEN_W'(MAX_FRAME))); // R5
    AST_BIG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err_big |-> (tx_len == '0 && rx_cap == '0 && !key_insert)); // R5
    AST_INVAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err_inval |-> (tx_len == '0 && rx_cap == '0 && !key_insert)); // R6
    AST_KEY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        key_insert |-> (rx_cap == LEN_W'(2))); // R7
    AST_REPLY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_code == $past(rx_hi))); // R8
endmodule

bind aux_frame_fmt auxf_chk #(.MAX_FRAME(MAX_FRAME)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_cmd    (req_cmd),
    .req_addr   (req_addr),
    .tx_valid   (tx_valid),
    .tx_head    (tx_data[31:0]),
    .tx_len     (tx_len),
    .rx_cap     (rx_cap),
    .key_insert (key_insert),
    .err_big    (err_big),
    .err_inval  (err_inval),
    .rx_valid   (rx_valid),
    .rx_hi      (rx_data[7:4]),
    .res_valid  (res_valid),
    .res_code   (res_code)
);

// File: tb/tb_aux_frame_fmt.sv
module tb_aux_frame_fmt;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [3:0]   req_cmd = '0;
    logic [19:0]  req_addr = '0;
    logic [4:0]   req_size = '0;
    logic [127:0] req_wdata = '0;
    logic         tx_valid;
    logic [159:0] tx_data;
    logic [4:0]   tx_len, rx_cap;
    logic         key_insert, err_big, err_inval;
    logic         rx_valid = 1'b0;
    logic [4:0]   rx_len = '0;
    logic [159:0] rx_data = '0;
    logic         res_valid;
    logic [3:0]   res_code;
    logic [4:0]   res_count;
    logic [151:0] rd_data;

    int nchk = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    aux_frame_fmt dut (.*);

    task automatic chk(input string what, input logic [159:0] act, input logic [159:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // Offer a request and check every framing output against the requirement model.
    task automatic do_req(input string tag, input logic [3:0] cmd, input logic [19:0] addr,
                          input logic [4:0] size, input logic [127:0] wd);
        logic [3:0] m;
        bit wr, rd, big, inval, key;
        int el, ec;
        logic [159:0] ef;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_size = size; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        m  = cmd & 4'hB;
        wr = (m == 4'h8) || (m == 4'h0) || (m == 4'h2);
        rd = (m == 4'h9) || (m == 4'h1);
        el = wr ? ((size == 0) ? 3 : 4 + int'(size)) : (rd ? ((size == 0) ? 3 : 4) : 0);
        ec = wr ? 2 : (rd ? int'(size) + 1 : 0);
        big = (wr || rd) && (el > 20 || ec > 20);
        inval = !(wr || rd);
        if (big || inval) begin el = 0; ec = 0; end
        key = (m == 4'h8) && (addr == 20'h68007) && !big;
        ef = '0;
        for (int i = 0; i < el; i++) begin
            logic [7:0] b;
            case (i)
                0: b = {cmd, addr[19:16]};
                1: b = addr[15:8];
                2: b = addr[7:0];
                3: b = 8'(size) - 8'd1;
                default: b = wd[8*(i-4) +: 8];
            endcase
            ef[8*i +: 8] = b;
        end
        chk({tag, " tx_valid"}, 160'(tx_valid), 160'(1));
        chk({tag, " tx_len"}, 160'(tx_len), 160'(el));
        chk({tag, " rx_cap"}, 160'(rx_cap), 160'(ec));
        chk({tag, " frame"}, tx_data, ef);
        chk({tag, " err_big"}, 160'(err_big), 160'(big));
        chk({tag, " err_inval"}, 160'(err_inval), 160'(inval));
        chk({tag, " key"}, 160'(key_insert), 160'(key));
        @(negedge clk);
        chk({tag, " tx_valid drop R11"}, 160'(tx_valid), 160'(0));
        chk({tag, " tx_len hold R11"}, 160'(tx_len), 160'(el));
    endtask

    // Offer a reply and check code, count and read payload.
    task automatic do_rx(input string tag, input logic [4:0] len, input logic [159:0] data,
                         input logic [3:0] ecode, input int ecnt, input logic [151:0] erd);
        @(negedge clk);
        rx_valid = 1'b1; rx_len = len; rx_data = data;
        @(negedge clk);
        rx_valid = 1'b0;
        chk({tag, " res_valid R11"}, 160'(res_valid), 160'(1));
        chk({tag, " code R8"}, 160'(res_code), 160'(ecode));
        chk({tag, " count"}, 160'(res_count), 160'(ecnt));
        chk({tag, " rd_data"}, 160'(rd_data), 160'(erd));
    endtask

    task automatic t_reset;
        chk("R11 reset tx_valid", 160'(tx_valid), 160'(0));
        chk("R11 reset tx_len", 160'(tx_len), 160'(0));
        chk("R11 reset frame", tx_data, '0);
        chk("R11 reset res_valid", 160'(res_valid), 160'(0));
    endtask

    task automatic t_write;
        do_req("R1 R2 native write 3", 4'h8, 20'h12345, 5'd3, 128'hCCBBAA);
        chk("R1 byte0", 160'(tx_data[7:0]), 160'(8'h81));
        chk("R1 byte3", 160'(tx_data[31:24]), 160'(8'h02));
        do_req("R2 status update 1", 4'h2, 20'h00050, 5'd1, 128'h5A);
        do_req("R2 i2c write 16", 4'h0, 20'h00050, 5'd16, 128'h0F0E0D0C0B0A09080706050403020100);
        do_req("R5 i2c write 17", 4'h0, 20'h00050, 5'd17, '1);
        do_req("R2 write zero size", 4'h8, 20'hABCDE, 5'd0, '1);
        chk("R2 zero tail", 160'(tx_data[31:24]), 160'(0));
    endtask

    task automatic t_read;
        do_req("R3 native read 19", 4'h9, 20'h00100, 5'd19, '1);
        do_req("R5 native read 20", 4'h9, 20'h00100, 5'd20, '0);
        do_req("R3 i2c read 5", 4'h1, 20'h00050, 5'd5, '1);
        chk("R3 byte3", 160'(tx_data[31:24]), 160'(8'h04));
        do_req("R3 read zero size", 4'h1, 20'h00050, 5'd0, '0);
    endtask

    task automatic t_cont_bit;
        do_req("R4 i2c read cont", 4'h5, 20'h00050, 5'd2, '0);
        chk("R4 byte0 keeps bit", 160'(tx_data[7:4]), 160'(4'h5));
        do_req("R4 status update cont", 4'h6, 20'h00050, 5'd2, 128'h2211);
        do_req("R4 R7 native write cont at key", 4'hC, 20'h68007, 5'd5, 128'h0504030201);
    endtask

    task automatic t_inval;
        do_req("R6 cmd 3", 4'h3, 20'h00001, 5'd1, '1);
        do_req("R6 cmd A", 4'hA, 20'h00001, 5'd1, '1);
        do_req("R6 cmd F", 4'hF, 20'h68007, 5'd1, '1);
    endtask

    task automatic t_key;
        do_req("R7 key write", 4'h8, 20'h68007, 5'd5, 128'h0504030201);
        chk("R7 flag set", 160'(key_insert), 160'(1));
        do_req("R7 neighbour addr", 4'h8, 20'h68008, 5'd5, '0);
        do_req("R7 i2c write at key", 4'h0, 20'h68007, 5'd5, '0);
        do_req("R7 read at key", 4'h9, 20'h68007, 5'd5, '0);
        do_req("R7 R5 oversize at key", 4'h8, 20'h68007, 5'd17, '0);
    endtask

    task automatic t_write_reply;
        do_req("R9 setup write 3", 4'h8, 20'h00200, 5'd3, 128'h030201);
        do_rx("R9 short count 2", 5'd2, 160'h0200, 4'h0, 2, '0);
        do_rx("R9 clamp to size", 5'd2, 160'h0910, 4'h1, 3, '0);
        do_rx("R9 one byte reply", 5'd1, 160'h20, 4'h2, 3, '0);
        do_rx("R9 long reply clipped", 5'd5, 160'h7766_55_01_00, 4'h0, 1, '0);
    endtask

    task automatic t_read_reply;
        do_req("R10 setup read 4", 4'h9, 20'h00300, 5'd4, '0);
        do_rx("R10 full reply", 5'd5, 160'h44332211_00, 4'h0, 4, 152'h44332211);
        do_rx("R10 short reply", 5'd3, 160'h44332211_20, 4'h2, 2, 152'h2211);
        do_rx("R10 clipped reply", 5'd8, 160'h77665544332211_00, 4'h0, 4, 152'h44332211);
        do_rx("R10 empty reply", 5'd0, 160'h99_F0, 4'hF, 0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_write();
        t_read();
        t_cont_bit();
        t_inval();
        t_key();
        t_write_reply();
        t_read_reply();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule